// File: doc/BRIEF.md
# Pi/4-Shift Differential QPSK Symbol Encoder

The encoder accepts a serial bit stream qualified by a per-bit strobe. It groups consecutive bits into two-bit symbols. Each symbol turns the carrier phase by an odd multiple of an eighth of a turn. The phase is held as an index in units of pi/4, and each new index is the previous index plus a step chosen by the symbol. This makes the encoding differential: the result depends on the previous state, not only on the current data. Because every step is odd, the phase moves by at least pi/4 on every symbol and never stays where it was.

For each symbol the block registers the new phase index and a pair of signed in-phase and quadrature amplitude codes. These codes go to external converters and filtering. A test-mode input swaps the serial data for an internal pseudo-random source with a period of 511 bits. That source is paced by the same strobe, and its current bit is shown on a monitor output, so a bench or instrument can record the test pattern while it is being modulated.

Top module: `dqpsk_sym_enc`

## Requirements
- R1: The first strobed bit of each pair is Xk and the second is Yk. `sym_vld_o` is high for exactly one cycle, in the cycle after the clock edge that samples Yk, and it stays low after Xk alone.
- R2: The phase index (3 bits, units of pi/4, modulo 8) advances by 1 for {Xk,Yk}=00, by 3 for 01, by 7 for 10 and by 5 for 11.
- R3: Every symbol changes `phase_o` by an odd amount, so the change is never zero. `phase_o` holds its value in every cycle without a symbol.
- R4: With `sym_vld_o` high, `i_o`/`q_o` equal round(127·cos) and round(127·sin) of phase_o·45°. For indices 0 to 7, I = 127,90,0,-90,-127,-90,0,90 and Q = 0,90,127,90,0,-90,-127,-90 (two's complement, 8 bits).
- R5: The asynchronous reset `rst_ni` low sets `phase_o`=0, `i_o`=127, `q_o`=0 and `sym_vld_o`=0. It also discards a half-received pair, so the next strobed bit is Xk.
- R6: With `test_mode_i` high, strobed bits come from the internal sequence and `bit_i` is ignored. `pn_o` shows the bit that the next strobe consumes. With `test_mode_i` low, `pn_o` is 0.
- R7: The sequence comes from x^9+x^5+1 seeded with all ones. Its first nine bits are 1, its tenth bit is 0, and it repeats every 511 bits.
- R8: Cycles with `bit_vld_i` low change nothing. A pending Xk is still paired with the next strobed bit, and the sequence neither advances nor restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bit_i | input | 1 | Serial data bit |
| bit_vld_i | input | 1 | Strobe: consume one bit this cycle |
| test_mode_i | input | 1 | Use the internal pseudo-random source |
| pn_o | output | 1 | Monitor of the next source bit in test mode |
| sym_vld_o | output | 1 | One-cycle symbol pulse |
| phase_o | output | 3 | Accumulated phase index, units of pi/4 |
| i_o | output | 8 | Signed in-phase amplitude code |
| q_o | output | 8 | Signed quadrature amplitude code |

## Verification
A wrong phase state persists, because the encoding is differential. A single bad increment offsets every later `phase_o` and I/Q pair, and the error shows on the symbol pulse that follows it. A pairing slip swaps Xk and Yk roles and shows up as wrong steps within one symbol. A corrupted sequence register breaks the recorded `pn_o` stream: the nine leading ones break at once, and the 511-bit repeat breaks within one period.

// File: rtl/dqpsk_pkg.sv
package dqpsk_pkg;
  localparam int PH_W  = 3;
  localparam int AMP_W = 8;

  typedef logic [PH_W-1:0]         phase_t;
  typedef logic signed [AMP_W-1:0] amp_t;
  typedef struct packed {
    amp_t i;
    amp_t q;
  } iq_t;

  function automatic phase_t dibit_step(input logic x, input logic y);
    case ({x, y})
      2'b00:   return phase_t'(1);
      2'b01:   return phase_t'(3);
      2'b10:   return phase_t'(7);
      default: return phase_t'(5);
    endcase
  endfunction

  // diagonal = round(amp * 0.7071) via 181/256
  function automatic iq_t iq_lut(input phase_t k, input int amp);
    iq_t r;
    int  d;
    d = (amp * 181 + 128) / 256;
    case (k)
      3'd0:    begin r.i = amp_t'(amp);  r.q = amp_t'(0);    end
      3'd1:    begin r.i = amp_t'(d);    r.q = amp_t'(d);    end
      3'd2:    begin r.i = amp_t'(0);    r.q = amp_t'(amp);  end
      3'd3:    begin r.i = amp_t'(-d);   r.q = amp_t'(d);    end
      3'd4:    begin r.i = amp_t'(-amp); r.q = amp_t'(0);    end
      3'd5:    begin r.i = amp_t'(-d);   r.q = amp_t'(-d);   end
      3'd6:    begin r.i = amp_t'(0);    r.q = amp_t'(-amp); end
      default: begin r.i = amp_t'(d);    r.q = amp_t'(-d);   end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/dqpsk_pair.sv
module dqpsk_pair (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  input  logic bit_vld_i,
  output logic pair_vld_o,
  output logic x_o,
  output logic y_o
);
  logic half_q, x_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= 1'b0;
      x_q    <= 1'b0;
    end else if (bit_vld_i) begin
      half_q <= ~half_q;
      if (!half_q) x_q <= bit_i;
    end
  end

  assign pair_vld_o = bit_vld_i & half_q;
  assign x_o        = x_q;
  assign y_o        = bit_i;
endmodule

// File: rtl/dqpsk_pn.sv
module dqpsk_pn #(
  parameter int LEN = 9,
  parameter int TAP = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  output logic bit_o
);
  logic [LEN-1:0] state_q;
  logic           fb;

  assign fb    = state_q[LEN-1] ^ state_q[TAP-1];
  assign bit_o = state_q[LEN-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= '1;
    else if (step_i) state_q <= {state_q[LEN-2:0], fb};
  end
endmodule

// File: rtl/dqpsk_map.sv
module dqpsk_map
  import dqpsk_pkg::*;
#(
  parameter int AMP = 127
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   pair_vld_i,
  input  logic   x_i,
  input  logic   y_i,
  output logic   sym_vld_o,
  output phase_t phase_o,
  output amp_t   i_o,
  output amp_t   q_o
);
  phase_t phase_q, phase_d;
  iq_t    iq_q, iq_rst;
  logic   vld_q;

  assign phase_d = phase_q + dibit_step(x_i, y_i);
  assign iq_rst  = iq_lut(phase_t'(0), AMP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      iq_q    <= iq_rst;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= pair_vld_i;
      if (pair_vld_i) begin
        phase_q <= phase_d;
        iq_q    <= iq_lut(phase_d, AMP);
      end
    end
  end

  assign sym_vld_o = vld_q;
  assign phase_o   = phase_q;
  assign i_o       = iq_q.i;
  assign q_o       = iq_q.q;
endmodule

// File: rtl/dqpsk_sym_enc.sv
module dqpsk_sym_enc
  import dqpsk_pkg::*;
#(
  parameter int PN_LEN = 9,
  parameter int PN_TAP = 5,
  parameter int AMP    = 127
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_i,
  input  logic             bit_vld_i,
  input  logic             test_mode_i,
  output logic             pn_o,
  output logic             sym_vld_o,
  output logic [PH_W-1:0]  phase_o,
  output logic [AMP_W-1:0] i_o,
  output logic [AMP_W-1:0] q_o
);
  logic pn_bit, src_bit, pair_vld, x_b, y_b;
  amp_t i_s, q_s;

  dqpsk_pn #(.LEN(PN_LEN), .TAP(PN_TAP)) u_pn (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (test_mode_i & bit_vld_i),
    .bit_o  (pn_bit)
  );

  assign src_bit = test_mode_i ? pn_bit : bit_i;
  assign pn_o    = test_mode_i & pn_bit;

  dqpsk_pair u_pair (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_i      (src_bit),
    .bit_vld_i  (bit_vld_i),
    .pair_vld_o (pair_vld),
    .x_o        (x_b),
    .y_o        (y_b)
  );

  dqpsk_map #(.AMP(AMP)) u_map (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pair_vld_i (pair_vld),
    .x_i        (x_b),
    .y_i        (y_b),
    .sym_vld_o  (sym_vld_o),
    .phase_o    (phase_o),
    .i_o        (i_s),
    .q_o        (q_s)
  );

  assign i_o = i_s;
  assign q_o = q_s;
endmodule

// File: rtl/dqpsk_sym_enc_chk.sv
module dqpsk_sym_enc_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bit_vld_i,
  input logic       sym_vld_o,
  input logic [2:0] phase_o
);
  // R1
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_vld_o |=> !sym_vld_o);
  // R1
  strobe_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_vld_o |-> $past(bit_vld_i));
  // R3
  nonzero_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_vld_o |-> phase_o != $past(phase_o));
  // R3
  odd_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_vld_o |-> phase_o[0] != $past(phase_o[0]));
  // R3
  phase_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sym_vld_o |-> $stable(phase_o));
endmodule

bind dqpsk_sym_enc dqpsk_sym_enc_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bit_vld_i (bit_vld_i),
  .sym_vld_o (sym_vld_o),
  .phase_o   (phase_o)
);

// File: tb/tb_dqpsk_sym_enc.sv
module tb_dqpsk_sym_enc;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_ni, bit_i, bit_vld_i, test_mode_i;
  logic              pn_o, sym_vld_o;
  logic [2:0]        phase_o;
  logic signed [7:0] i_o, q_o;

  dqpsk_sym_enc dut (
    .clk_i(clk), .rst_ni(rst_ni), .bit_i(bit_i), .bit_vld_i(bit_vld_i),
    .test_mode_i(test_mode_i), .pn_o(pn_o), .sym_vld_o(sym_vld_o),
    .phase_o(phase_o), .i_o(i_o), .q_o(q_o)
  );

  localparam int COS_T [8] = '{127, 90, 0, -90, -127, -90, 0, 90};
  localparam int SIN_T [8] = '{0, 90, 127, 90, 0, -90, -127, -90};
  // {Xk, Yk, expected phase from 0}
  localparam logic [4:0] VEC [14] = '{
    {2'b00,3'd1}, {2'b01,3'd4}, {2'b10,3'd3}, {2'b11,3'd0}, {2'b11,3'd5},
    {2'b00,3'd6}, {2'b10,3'd5}, {2'b01,3'd0}, {2'b01,3'd3}, {2'b01,3'd6},
    {2'b10,3'd5}, {2'b10,3'd4}, {2'b01,3'd7}, {2'b01,3'd2}};

  int errs = 0, checks = 0, ph_m = 0;
  logic              o_vld;
  logic [2:0]        o_ph;
  logic signed [7:0] o_i, o_q;
  logic              pn_seq [1022];

  function automatic int exp_step(input logic x, input logic y);
    if (!x && !y) return 1;
    if (!x &&  y) return 3;
    if ( x && !y) return 7;
    return 5;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); bit_i = b; bit_vld_i = 1'b1;
    @(negedge clk);
    o_vld = sym_vld_o; o_ph = phase_o; o_i = i_o; o_q = q_o;
    bit_vld_i = 1'b0;
  endtask

  task automatic check_sym(input string req);
    chk("R1", "sym pulse", int'(o_vld), 1);
    chk(req, "phase", int'(o_ph), ph_m);
    chk("R4", "I code", int'(o_i), COS_T[ph_m]);
    chk("R4", "Q code", int'(o_q), SIN_T[ph_m]);
  endtask

  initial begin
    rst_ni = 1'b0; bit_i = 1'b0; bit_vld_i = 1'b0; test_mode_i = 1'b0;
    repeat (3) @(negedge clk);
    // R5 reset state
    chk("R5", "reset vld", int'(sym_vld_o), 0);
    chk("R5", "reset phase", int'(phase_o), 0);
    chk("R5", "reset I", int'(i_o), 127);
    chk("R5", "reset Q", int'(q_o), 0);
    chk("R6", "pn_o mode off", int'(pn_o), 0);
    rst_ni = 1'b1;

    // R2 vector walk
    foreach (VEC[n]) begin
      send_bit(VEC[n][4]);
      chk("R1", "no sym after Xk", int'(o_vld), 0);
      send_bit(VEC[n][3]);
      ph_m = int'(VEC[n][2:0]);
      check_sym("R2");
      @(negedge clk);
      chk("R1", "pulse one cycle", int'(sym_vld_o), 0);
      chk("R3", "phase held", int'(phase_o), ph_m);
    end

    // R1 back-to-back strobes, di-bit 11
    @(negedge clk); bit_i = 1'b1; bit_vld_i = 1'b1;
    @(negedge clk); chk("R1", "no sym mid pair", int'(sym_vld_o), 0);
    @(negedge clk); bit_vld_i = 1'b0;
    o_vld = sym_vld_o; o_ph = phase_o; o_i = i_o; o_q = q_o;
    ph_m = (ph_m + 5) % 8;
    check_sym("R2");

    // R8 gap between Xk and Yk, di-bit 00
    send_bit(1'b0);
    repeat (6) @(negedge clk);
    chk("R8", "idle no sym", int'(sym_vld_o), 0);
    chk("R8", "idle phase", int'(phase_o), ph_m);
    send_bit(1'b0);
    ph_m = (ph_m + 1) % 8;
    check_sym("R8");

    // R5 reset in mid pair
    send_bit(1'b1);
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk);
    chk("R5", "mid reset phase", int'(phase_o), 0);
    rst_ni = 1'b1; ph_m = 0;
    send_bit(1'b0); send_bit(1'b1);
    ph_m = 3;
    check_sym("R5");

    // R6/R7 test mode
    @(negedge clk); test_mode_i = 1'b1;
    begin
      int bad_sym = 0, bad_rep = 0, ones = 0;
      for (int n = 0; n < 1022; n++) begin
        @(negedge clk);
        pn_seq[n] = pn_o;
        bit_i = ~pn_o; bit_vld_i = 1'b1;
        @(negedge clk);
        bit_vld_i = 1'b0;
        if (n % 2 == 1) begin
          ph_m = (ph_m + exp_step(pn_seq[n-1], pn_seq[n])) % 8;
          if (!sym_vld_o || int'(phase_o) != ph_m || int'(i_o) != COS_T[ph_m]
              || int'(q_o) != SIN_T[ph_m]) bad_sym++;
        end
      end
      for (int k = 0; k < 511; k++) if (pn_seq[k] != pn_seq[k+511]) bad_rep++;
      for (int k = 0; k < 9; k++) if (pn_seq[k]) ones++;
      chk("R6", "symbols from test source mismatches", bad_sym, 0);
      chk("R7", "leading ones", ones, 9);
      chk("R7", "tenth bit", int'(pn_seq[9]), 0);
      chk("R7", "period 511 mismatches", bad_rep, 0);
    end

    // R8 idle in test mode: source and phase hold
    begin
      logic pn_hold;
      @(negedge clk); pn_hold = pn_o;
      repeat (10) @(negedge clk);
      chk("R8", "pn hold", int'(pn_o), int'(pn_hold));
      chk("R8", "phase hold test", int'(phase_o), ph_m);
      chk("R8", "pn no restart", int'(pn_o), int'(pn_seq[0]));
    end
    test_mode_i = 1'b0;
    @(negedge clk);
    chk("R6", "pn_o low after mode off", int'(pn_o), 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule